// File: doc/BRIEF.md
# Fly-by Single-Address DMA Channel

This block is one DMA channel that moves words between a single peripheral and memory without ever holding the data. In each transfer it puts the memory location on the address bus and raises one memory strobe. In the same cycle it selects the peripheral's buffer register and sets the peripheral's direction line. Memory and peripheral then exchange the word directly over the shared data bus. The channel has no source address register, because the peripheral side of each transfer is implied by the select line.

Software loads a start address, a transfer count and a direction, then sets the enable bit. From then on the peripheral paces the work by holding its active-low request line low. After every completed item the address steps up by one word and the count steps down. When the count reaches zero, the channel drops its enable and raises a sticky completion interrupt, which stays set until software clears it with a register write.

Top module: `flyby_dma_chan`

## Requirements
- R1: After reset, mem_rd, mem_wr, dev_sel and done_irq are low, and the address, count and control registers all read back as zero.
- R2: Register index 0 holds the memory address, index 1 the count and index 2 the control word, where bit 0 is enable and bit 1 is direction (1 means peripheral to memory). Reading index 2 returns {done_irq, direction, enable} in bits 2:0. reg_rdata shows the register selected by reg_idx one clock later.
- R3: A bus cycle starts only when three things hold together: enable is set, the count is nonzero, and the synchronized dev_req_n is low. While the request is held high, no bus cycle occurs.
- R4: With direction 0, every cycle drives mem_rd together with dev_sel and dev_rnw=0. With direction 1, every cycle drives mem_wr together with dev_sel and dev_rnw=1. While dev_sel is high, exactly one memory strobe is high.
- R5: A bus cycle stays active, with its strobes unchanged, until mem_rdy is high at a clock edge. Each wait cycle therefore adds exactly one cycle to that item.
- R6: Each completed cycle adds one to the address, wrapping modulo 2^ADDR_W, and subtracts one from the count. mem_addr always shows the current address.
- R7: After each completed cycle the channel stays idle for SYNC_STAGES cycles before it examines the request again. A peripheral that raises dev_req_n when it sees the end of its last wanted strobe therefore gets no extra cycle.
- R8: When the count reaches zero, enable clears and done_irq sets. If enable is set while the count is already zero, the same happens without any bus cycle.
- R9: done_irq stays high until software writes to register index 3. If completion and the clear fall in the same cycle, the completion wins.
- R10: Writes to the address or count register, and the direction bit of a control write, are ignored while the channel is enabled or a bus cycle is in progress.
- R11: While dev_sel is high, dev_reg carries the BUF_REG parameter value, which is the peripheral's buffer register index.
- R12: Writing enable to 0 stops the channel after any cycle already in progress. No further cycles start, and the address and count keep their values for that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index for write and read-back |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Registered read-back of the selected register |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Memory read strobe (memory drives the data bus) |
| mem_wr | output | 1 | Memory write strobe (memory takes from the data bus) |
| mem_rdy | input | 1 | Memory completes the current cycle |
| dev_sel | output | 1 | Peripheral select |
| dev_rnw | output | 1 | 1: peripheral drives the data bus; 0: peripheral takes data |
| dev_reg | output | DEV_REG_W | Peripheral register index during select |
| dev_req_n | input | 1 | Asynchronous active-low transfer request |
| done_irq | output | 1 | Sticky completion interrupt |

## Verification
The bench builds the channel with ADDR_W=12, CNT_W=4 and SYNC_STAGES=2, and places a 4096-word memory model beside it. Because the address is narrow, a transfer that starts at 0xFFE crosses the wrap to zero within three items. The small count width keeps each transfer to a few items, so the terminal count and a zero-length enable are both quick to reach. A peripheral model that lifts its request after a set number of strobes tests the two-stage recovery gap, and a memory model that inserts two wait states per item exposes any strobe that ends early.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_RECOV = 2'd2
  } xfer_state_e;

  localparam logic [1:0] IDX_ADDR  = 2'd0;
  localparam logic [1:0] IDX_COUNT = 2'd1;
  localparam logic [1:0] IDX_CTRL  = 2'd2;
  localparam logic [1:0] IDX_IRQCL = 2'd3;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_DIR_BIT = 1;
endpackage

// File: rtl/flyby_req_sync.sv
module flyby_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n_async,
  output logic req_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= 1'b1;
        else     chain_q <= req_n_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], req_n_async};
      end
    end
  endgenerate

  assign req_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/flyby_dma_regs.sv
module flyby_dma_regs
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        idx,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              busy,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              en_q,
  output logic              dir_q,
  output logic              irq_q
);
  logic setup_ok;
  logic last_item;
  logic empty_start;
  logic irq_clear;

  assign setup_ok    = !en_q && !busy;
  assign last_item   = xfer_done && (count_q == CNT_W'(1));
  assign empty_start = en_q && (count_q == '0);
  assign irq_clear   = wr_en && (idx == IDX_IRQCL);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      count_q <= '0;
      en_q    <= 1'b0;
      dir_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_en && idx == IDX_ADDR && setup_ok)
        addr_q <= wr_data[ADDR_W-1:0];
      if (wr_en && idx == IDX_COUNT && setup_ok)
        count_q <= wr_data[CNT_W-1:0];
      if (wr_en && idx == IDX_CTRL) begin
        en_q <= wr_data[CTRL_EN_BIT];
        if (setup_ok) dir_q <= wr_data[CTRL_DIR_BIT];
      end
      if (xfer_done) begin
        addr_q  <= addr_q + 1'b1;
        count_q <= count_q - 1'b1;
      end
      if (last_item || empty_start) begin
        en_q  <= 1'b0;
        irq_q <= 1'b1;
      end else if (irq_clear) begin
        irq_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (idx)
        IDX_ADDR:  rd_data <= REG_W'(addr_q);
        IDX_COUNT: rd_data <= REG_W'(count_q);
        IDX_CTRL:  rd_data <= REG_W'({irq_q, dir_q, en_q});
        default:   rd_data <= '0;
      endcase
    end
  end

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> count_q == $past(count_q) - 1'b1);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> addr_q == $past(addr_q) + 1'b1);

  // R8
  terminal_off_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && count_q == '0) |=> (!en_q && irq_q));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !(wr_en && idx == IDX_IRQCL)) |=> irq_q);

  // R10
  setup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && !xfer_done) |=> $stable(addr_q) && $stable(count_q));
endmodule

// File: rtl/flyby_xfer_fsm.sv
module flyby_xfer_fsm
  import flyby_dma_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic dir,
  input  logic count_nz,
  input  logic req_n_s,
  input  logic mem_rdy,
  output logic mem_rd,
  output logic mem_wr,
  output logic dev_sel,
  output logic dev_rnw,
  output logic xfer_done,
  output logic busy
);
  localparam int RC_W = (SYNC_STAGES > 1) ? $clog2(SYNC_STAGES) : 1;

  xfer_state_e state_q;
  logic [RC_W-1:0] rec_q;
  logic go;

  assign go        = en && count_nz && !req_n_s;
  assign xfer_done = (state_q == ST_XFER) && mem_rdy;
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rec_q   <= '0;
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      dev_sel <= 1'b0;
      dev_rnw <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go) begin
            state_q <= ST_XFER;
            mem_rd  <= !dir;
            mem_wr  <= dir;
            dev_sel <= 1'b1;
            dev_rnw <= dir;
          end
        end
        ST_XFER: begin
          if (mem_rdy) begin
            state_q <= ST_RECOV;
            rec_q   <= RC_W'(SYNC_STAGES - 1);
            mem_rd  <= 1'b0;
            mem_wr  <= 1'b0;
            dev_sel <= 1'b0;
            dev_rnw <= 1'b0;
          end
        end
        ST_RECOV: begin
          if (rec_q == '0) state_q <= ST_IDLE;
          else             rec_q   <= rec_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  strobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    dev_sel |-> ($countones({mem_rd, mem_wr}) == 1) && (mem_wr == dev_rnw));

  // R4
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !dev_sel |-> !mem_rd && !mem_wr);

  // R3
  start_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_sel) |-> $past(!req_n_s && en && count_nz));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_sel && !mem_rdy) |=> dev_sel && $stable(mem_rd) && $stable(mem_wr));

  // R7
  recovery_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dev_sel) |=> !dev_sel);
endmodule

// File: rtl/flyby_dma_chan.sv
module flyby_dma_chan
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 12,
  parameter int REG_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DEV_REG_W   = 2,
  parameter int BUF_REG     = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_idx,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_rd,
  output logic                 mem_wr,
  input  logic                 mem_rdy,
  output logic                 dev_sel,
  output logic                 dev_rnw,
  output logic [DEV_REG_W-1:0] dev_reg,
  input  logic                 dev_req_n,
  output logic                 done_irq
);
  logic              req_n_s;
  logic              busy;
  logic              xfer_done;
  logic [CNT_W-1:0]  count_q;
  logic              en_q;
  logic              dir_q;

  flyby_req_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk         (clk),
    .rst         (rst),
    .req_n_async (dev_req_n),
    .req_n_sync  (req_n_s)
  );

  flyby_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .idx       (reg_idx),
    .wr_data   (reg_wdata),
    .rd_data   (reg_rdata),
    .busy      (busy),
    .xfer_done (xfer_done),
    .addr_q    (mem_addr),
    .count_q   (count_q),
    .en_q      (en_q),
    .dir_q     (dir_q),
    .irq_q     (done_irq)
  );

  flyby_xfer_fsm #(.SYNC_STAGES(SYNC_STAGES)) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en_q),
    .dir       (dir_q),
    .count_nz  (|count_q),
    .req_n_s   (req_n_s),
    .mem_rdy   (mem_rdy),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .dev_sel   (dev_sel),
    .dev_rnw   (dev_rnw),
    .xfer_done (xfer_done),
    .busy      (busy)
  );

  assign dev_reg = DEV_REG_W'(BUF_REG);

  // R11
  buf_reg_sel_chk: assert property (@(posedge clk) disable iff (rst)
    dev_sel |-> dev_reg == DEV_REG_W'(BUF_REG));
endmodule

// File: tb/flyby_dma_chan_tb.sv
module flyby_dma_chan_tb_top;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 4;
  localparam int REG_W  = 16;
  localparam int SYNC   = 2;
  localparam int DRW    = 2;
  localparam int BUFR   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              reg_wr = 1'b0;
  logic [1:0]        reg_idx = 2'd0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [REG_W-1:0]  reg_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rd, mem_wr, mem_rdy;
  logic              dev_sel, dev_rnw;
  logic [DRW-1:0]    dev_reg;
  logic              dev_req_n;
  logic              done_irq;

  flyby_dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W),
                   .SYNC_STAGES(SYNC), .DEV_REG_W(DRW), .BUF_REG(BUFR)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdy(mem_rdy), .dev_sel(dev_sel),
    .dev_rnw(dev_rnw), .dev_reg(dev_reg), .dev_req_n(dev_req_n),
    .done_irq(done_irq)
  );

  int checks = 0;
  int fails  = 0;

  // memory and peripheral models
  logic [15:0] mem [0:4095];
  logic [15:0] rx  [0:15];
  int  items    = 0;
  int  rx_n     = 0;
  int  sel_cyc  = 0;
  int  pair_err = 0;
  int  reg_err  = 0;
  logic req_man  = 1'b1;
  logic auto_req = 1'b0;
  int  pend     = 0;
  logic wait_en  = 1'b0;
  int  wcnt     = 0;

  assign dev_req_n = auto_req ? (pend == 0) : req_man;

  always @(negedge clk) begin
    if (!dev_sel) wcnt = 0;
    else          wcnt = wcnt + 1;
    mem_rdy = wait_en ? (dev_sel && wcnt >= 3) : 1'b1;
  end

  always @(posedge clk) begin
    if (dev_sel) begin
      sel_cyc <= sel_cyc + 1;
      if (!((mem_rd && !mem_wr && !dev_rnw) || (mem_wr && !mem_rd && dev_rnw)))
        pair_err <= pair_err + 1;
      if (dev_reg != DRW'(BUFR)) reg_err <= reg_err + 1;
      if (mem_rdy) begin
        items <= items + 1;
        if (mem_wr) mem[mem_addr] <= 16'h5A00 + 16'(items);
        if (mem_rd) begin
          rx[rx_n[3:0]] <= mem[mem_addr];
          rx_n <= rx_n + 1;
        end
        if (pend > 0) pend <= pend - 1;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] i, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = i; reg_wdata = REG_W'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] i, output int v);
    @(negedge clk);
    reg_idx = i;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic t_reset();
    int v;
    check(!mem_rd && !mem_wr && !dev_sel && !done_irq, "R1 strobes/irq after reset",
          {mem_rd, mem_wr, dev_sel, done_irq}, 0);
    rd_reg(2'd0, v); check(v == 0, "R1 addr reset", v, 0);
    rd_reg(2'd1, v); check(v == 0, "R1 count reset", v, 0);
    rd_reg(2'd2, v); check(v == 0, "R1 ctrl reset", v, 0);
  endtask

  task automatic t_p2m();
    int v, base;
    base = items;
    wr_reg(2'd0, 'h010);
    wr_reg(2'd1, 4);
    wr_reg(2'd2, 3);
    req_man = 1'b0;
    repeat (40) @(negedge clk);
    req_man = 1'b1;
    for (int k = 0; k < 4; k++)
      check(mem['h010 + k] == 16'h5A00 + 16'(base + k), "R4 periph-to-mem data",
            mem['h010 + k], 16'h5A00 + base + k);
    rd_reg(2'd0, v); check(v == 'h014, "R6 address after four items", v, 'h014);
    rd_reg(2'd1, v); check(v == 0, "R6 count after four items", v, 0);
    rd_reg(2'd2, v); check(v == 'b110, "R2 R8 ctrl shows irq, dir, enable off", v, 'b110);
    check(done_irq, "R8 done_irq raised", done_irq, 1);
  endtask

  task automatic t_irq_clear();
    repeat (10) @(negedge clk);
    check(done_irq, "R9 done_irq sticky", done_irq, 1);
    wr_reg(2'd3, 0);
    @(negedge clk);
    check(!done_irq, "R9 done_irq cleared by index 3 write", done_irq, 0);
  endtask

  task automatic t_m2p_wrap();
    int v, r0, s0;
    mem['hFFE] = 16'h1111; mem['hFFF] = 16'h2222; mem['h000] = 16'h3333;
    r0 = rx_n; s0 = sel_cyc;
    wait_en = 1'b1;
    wr_reg(2'd0, 'hFFE);
    wr_reg(2'd1, 3);
    wr_reg(2'd2, 1);
    req_man = 1'b0;
    repeat (50) @(negedge clk);
    req_man = 1'b1;
    wait_en = 1'b0;
    check(rx_n - r0 == 3, "R4 mem-to-periph item count", rx_n - r0, 3);
    check(rx[r0[3:0]] == 16'h1111 && rx[4'(r0 + 1)] == 16'h2222 && rx[4'(r0 + 2)] == 16'h3333,
          "R4 mem-to-periph data order", rx[4'(r0 + 2)], 16'h3333);
    rd_reg(2'd0, v); check(v == 'h001, "R6 address wraps past top", v, 'h001);
    check(sel_cyc - s0 == 9, "R5 two wait states per item", sel_cyc - s0, 9);
    wr_reg(2'd3, 0);
  endtask

  task automatic t_gate_and_stop();
    int v, base, moved;
    base = items;
    wr_reg(2'd0, 'h100);
    wr_reg(2'd1, 8);
    wr_reg(2'd2, 3);
    repeat (20) @(negedge clk);
    check(items == base, "R3 no cycle while request high", items - base, 0);
    wr_reg(2'd0, 'h200);
    wr_reg(2'd1, 1);
    wr_reg(2'd2, 1);
    rd_reg(2'd0, v); check(v == 'h100, "R10 address write ignored while enabled", v, 'h100);
    rd_reg(2'd1, v); check(v == 8, "R10 count write ignored while enabled", v, 8);
    rd_reg(2'd2, v); check(v == 'b011, "R10 direction kept while enabled", v, 'b011);
    req_man = 1'b0;
    for (int t = 0; t < 50 && items == base; t++) @(negedge clk);
    wr_reg(2'd2, 2);
    req_man = 1'b1;
    repeat (20) @(negedge clk);
    moved = items - base;
    check(moved >= 1 && moved < 8, "R12 stop leaves transfer partial", moved, 1);
    rd_reg(2'd1, v); check(v == 8 - moved, "R12 count kept at stop", v, 8 - moved);
    rd_reg(2'd0, v); check(v == 'h100 + moved, "R12 address kept at stop", v, 'h100 + moved);
    check(!done_irq, "R12 no irq on stop", done_irq, 0);
  endtask

  task automatic t_recovery();
    int v, base;
    base = items;
    wr_reg(2'd0, 'h300);
    wr_reg(2'd1, 5);
    pend = 2;
    auto_req = 1'b1;
    wr_reg(2'd2, 3);
    repeat (40) @(negedge clk);
    check(items - base == 2, "R7 request lifted after two strobes gives two items",
          items - base, 2);
    rd_reg(2'd1, v); check(v == 3, "R7 count after early stop", v, 3);
    check(!done_irq, "R7 no irq with count left", done_irq, 0);
    wr_reg(2'd2, 0);
    auto_req = 1'b0;
  endtask

  task automatic t_zero();
    int v, base;
    base = items;
    wr_reg(2'd1, 0);
    req_man = 1'b0;
    wr_reg(2'd2, 1);
    repeat (10) @(negedge clk);
    req_man = 1'b1;
    check(items == base, "R8 zero count runs no cycle", items - base, 0);
    check(done_irq, "R8 zero count raises irq", done_irq, 1);
    rd_reg(2'd2, v); check(v[0] == 1'b0, "R8 zero count clears enable", v, 'b100);
    wr_reg(2'd3, 0);
  endtask

  task automatic finish_run();
    check(pair_err == 0, "R4 strobe pairing during select", pair_err, 0);
    check(reg_err == 0, "R11 buffer register index on dev_reg", reg_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_p2m();
    t_irq_clear();
    t_m2p_wrap();
    t_gate_and_stop();
    t_recovery();
    t_zero();
    finish_run();
  end
endmodule